// File: doc/BRIEF.md
# Direct-Mode Wired Interrupt Domain Controller

This block collects a small set of wired interrupt lines and routes each one to a single hart. Every source carries its own configuration word, which selects how input activity turns into a pending flag (edge, level, detached or off), and a target word, whose upper bits name the hart that receives it. Two global write-only locations set or clear a source's enable bit by source number. The domain has one global enable, and no hart interrupt is raised while it is off.

Each hart owns a 32-byte control window. Reading that window's claim location hands back the lowest-numbered pending source routed to the hart and clears its pending flag in the same access. Software reaches the block through a simple 32-bit register port. A read returns its data one cycle after the request. Each hart has one level interrupt output.

Top module: `irq_domain_ctrl`

## Requirements
- R1: The domain word at offset 0x0000 keeps only bit 8, the global enable, and reads it back in bit 8 with all other bits 0. When a write clears it, every `irq_o` bit is 0 from the next cycle.
- R2: While the global enable is clear, no source's pending flag can go from 0 to 1.
- R3: Source N (1 to NUM_SRC) has its configuration word at 0x0004 + 4*(N-1). When bit 10 (delegate) is set, input activity on that source leaves its pending flag unchanged.
- R4: Configuration bits 2:0 select the mode: 0 off, 1 detached, 2 and 3 reserved, 4 rising, 5 falling, 6 active-high level, 7 active-low level. In modes 0 to 3, input activity never changes pending.
- R5: Rising mode sets pending on a 0-to-1 input transition and clears it on a 1-to-0 transition. Falling mode does the reverse. Each input goes through one register before edge detection, so pending changes two clock edges after the input.
- R6: In the level modes, pending follows the input: set while the input is at its active level and cleared while it is not.
- R7: Writing a source number to 0x1EDC sets that source's enable bit, and writing it to 0x1FDC clears it. Values of 0 or above NUM_SRC have no effect. Both locations read as 0.
- R8: Source N's target word sits at 0x3004 + 4*(N-1) and reads back as written. Bits 31:18 give the destination hart index.
- R9: A read of hart H's claim location (0x4000 + 32*H + 0x1C) returns {6'b0, N[9:0], 16'b0}, where N is the lowest-numbered source that is pending and routed to H, whether or not it is enabled. The same access clears that source's pending flag. It returns 0 if no source qualifies.
- R10: A write to a claim location changes nothing. Window offsets 0x00, 0x04, 0x08 and 0x18 accept writes with no effect and read as 0.
- R11: `irq_o[H]` is 1 exactly when the global enable is set and some source routed to H is both enabled and pending.
- R12: When a claim clears a source in the same cycle that its input logic sets it, the set wins and the source stays pending.
- R13: Configuration words keep bits 10:0 and read back with the other bits 0. Unmapped or misaligned addresses read as 0 and ignore writes.
- R14: `rdata_o` holds the value of a read on the cycle after the request and keeps it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| src_i | input | NUM_SRC | Wired source lines; bit k is source k+1 |
| irq_o | output | NUM_HART | Interrupt output per hart |

## Verification
A claim read and a source's own set logic can act on the same pending flag at the same clock edge. The bench provokes this by claiming an active-high level source while its input is still held high. It judges the result by checking that the hart output stays high and that a second claim returns the same source number. A second overlap happens when the global enable drops while a source is pending: the output must fall at once, and a claim must still hand back that source.

// File: rtl/irq_domain_pkg.sv
package irq_domain_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_DETACH = 3'd1,
    MODE_RSV2   = 3'd2,
    MODE_RSV3   = 3'd3,
    MODE_RISE   = 3'd4,
    MODE_FALL   = 3'd5,
    MODE_HIGH   = 3'd6,
    MODE_LOW    = 3'd7
  } src_mode_e;

  localparam int unsigned CFG_BITS = 11;
  localparam int unsigned DLG_BIT  = 10;
  localparam int unsigned GIE_BIT  = 8;
  localparam int unsigned HART_LSB = 18;
  localparam int unsigned HART_W   = 14;

  localparam int unsigned OFS_DOMAIN = 32'h0000;
  localparam int unsigned OFS_CFG0   = 32'h0004;
  localparam int unsigned OFS_EN_SET = 32'h1EDC;
  localparam int unsigned OFS_EN_CLR = 32'h1FDC;
  localparam int unsigned OFS_TGT0   = 32'h3004;
  localparam int unsigned OFS_WIN0   = 32'h4000;
  localparam int unsigned WIN_CLAIM  = 32'h1C;

  function automatic logic [31:0] claim_word(input logic [9:0] num);
    return {6'b0, num, 16'b0};
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_domain_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gie_i,
  input  logic                line_i,
  input  logic                cfg_we_i,
  input  logic                tgt_we_i,
  input  logic [31:0]         wdata_i,
  input  logic                en_set_i,
  input  logic                en_clr_i,
  input  logic                claim_clr_i,
  output logic [CFG_BITS-1:0] cfg_o,
  output logic [31:0]         tgt_o,
  output logic                en_o,
  output logic                pend_o
);

  logic                line_s_q, line_p_q;
  logic [CFG_BITS-1:0] cfg_q;
  logic [31:0]         tgt_q;
  logic                en_q, pend_q, pend_d;
  logic                rise, fall, set_ev, clr_ev;
  src_mode_e           mode;

  assign mode = src_mode_e'(cfg_q[2:0]);
  assign rise = line_s_q & ~line_p_q;
  assign fall = ~line_s_q & line_p_q;

  always_comb begin
    set_ev = 1'b0;
    clr_ev = 1'b0;
    if (!cfg_q[DLG_BIT]) begin
      unique case (mode)
        MODE_RISE: begin set_ev = rise;      clr_ev = fall;      end
        MODE_FALL: begin set_ev = fall;      clr_ev = rise;      end
        MODE_HIGH: begin set_ev = line_s_q;  clr_ev = ~line_s_q; end
        MODE_LOW:  begin set_ev = ~line_s_q; clr_ev = line_s_q;  end
        default:   ;
      endcase
    end
  end

  // set outranks claim so a fresh event is never lost
  always_comb begin
    pend_d = pend_q;
    if (claim_clr_i || clr_ev) pend_d = 1'b0;
    if (set_ev && gie_i)       pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_s_q <= 1'b0;
      line_p_q <= 1'b0;
      cfg_q    <= '0;
      tgt_q    <= '0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      line_s_q <= line_i;
      line_p_q <= line_s_q;
      if (cfg_we_i) cfg_q <= wdata_i[CFG_BITS-1:0];
      if (tgt_we_i) tgt_q <= wdata_i;
      if (en_set_i)      en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
      pend_q <= pend_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign tgt_o  = tgt_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     cand_i,
  output logic             found_o,
  output logic [IDX_W-1:0] num_o
);

  // descending walk: the lowest index written last wins
  always_comb begin
    found_o = 1'b0;
    num_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        num_o   = IDX_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/irq_domain_ctrl.sv
module irq_domain_ctrl
  import irq_domain_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned NUM_HART = 2,
  parameter int unsigned ADDR_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_SRC-1:0]  src_i,
  output logic [NUM_HART-1:0] irq_o
);

  localparam int unsigned SRC_W  = $clog2(NUM_SRC + 1);
  localparam int unsigned HIDX_W = (NUM_HART > 1) ? $clog2(NUM_HART) : 1;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  localparam logic [ADDR_W-1:0] A_DOMAIN = ADDR_W'(OFS_DOMAIN);
  localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(OFS_CFG0);
  localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(OFS_CFG0 + 4 * (NUM_SRC - 1));
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);
  localparam logic [ADDR_W-1:0] A_TGT_LO = ADDR_W'(OFS_TGT0);
  localparam logic [ADDR_W-1:0] A_TGT_HI = ADDR_W'(OFS_TGT0 + 4 * (NUM_SRC - 1));
  localparam logic [ADDR_W-1:0] A_WIN_LO = ADDR_W'(OFS_WIN0);
  localparam logic [ADDR_W-1:0] A_WIN_HI = ADDR_W'(OFS_WIN0 + 32 * NUM_HART - 1);

  // access decode
  logic              rd, wr, aligned;
  logic              hit_dom, hit_cfg, hit_tgt, hit_win, hit_claim;
  logic              hit_en_set, hit_en_clr;
  logic [WIDX_W-1:0] cfg_idx, tgt_idx;
  logic [ADDR_W-1:0] tgt_off, win_off;
  logic [HIDX_W-1:0] claim_hart;

  assign rd         = req_i & ~we_i;
  assign wr         = req_i & we_i;
  assign aligned    = (addr_i[1:0] == 2'b00);
  assign hit_dom    = aligned && (addr_i == A_DOMAIN);
  assign hit_cfg    = aligned && (addr_i >= A_CFG_LO) && (addr_i <= A_CFG_HI);
  assign hit_tgt    = aligned && (addr_i >= A_TGT_LO) && (addr_i <= A_TGT_HI);
  assign hit_win    = aligned && (addr_i >= A_WIN_LO) && (addr_i <= A_WIN_HI);
  assign hit_en_set = (addr_i == A_EN_SET);
  assign hit_en_clr = (addr_i == A_EN_CLR);
  assign cfg_idx    = addr_i[ADDR_W-1:2];
  assign tgt_off    = addr_i - ADDR_W'(OFS_TGT0 - 4);
  assign tgt_idx    = tgt_off[ADDR_W-1:2];
  assign win_off    = addr_i - A_WIN_LO;
  assign claim_hart = win_off[5 +: HIDX_W];
  assign hit_claim  = hit_win && (win_off[4:0] == 5'(WIN_CLAIM));

  logic gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gie_q <= 1'b0;
    else if (wr && hit_dom) gie_q <= wdata_i[GIE_BIT];
  end

  // per-source state
  logic [CFG_BITS-1:0] cfg_arr [NUM_SRC];
  logic [31:0]         tgt_arr [NUM_SRC];
  logic [NUM_SRC-1:0]  en_vec, pend_vec, claim_clr, dlg_vec, det_vec;
  logic [NUM_SRC-1:0]  route [NUM_HART];
  logic                pick_found [NUM_HART];
  logic [SRC_W-1:0]    pick_num   [NUM_HART];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic cfg_we, tgt_we, en_set, en_clr;

    assign cfg_we = wr && hit_cfg && (cfg_idx == WIDX_W'(k + 1));
    assign tgt_we = wr && hit_tgt && (tgt_idx == WIDX_W'(k + 1));
    assign en_set = wr && hit_en_set && (wdata_i == 32'(k + 1));
    assign en_clr = wr && hit_en_clr && (wdata_i == 32'(k + 1));
    assign claim_clr[k] = rd && hit_claim && pick_found[claim_hart]
                          && (pick_num[claim_hart] == SRC_W'(k + 1));

    irq_src_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .gie_i       (gie_q),
      .line_i      (src_i[k]),
      .cfg_we_i    (cfg_we),
      .tgt_we_i    (tgt_we),
      .wdata_i     (wdata_i),
      .en_set_i    (en_set),
      .en_clr_i    (en_clr),
      .claim_clr_i (claim_clr[k]),
      .cfg_o       (cfg_arr[k]),
      .tgt_o       (tgt_arr[k]),
      .en_o        (en_vec[k]),
      .pend_o      (pend_vec[k])
    );

    assign dlg_vec[k] = cfg_arr[k][DLG_BIT];
    assign det_vec[k] = (cfg_arr[k][2:0] == MODE_DETACH);
  end

  // per-hart routing, claim pick and output
  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_rt
      assign route[h][k] = (tgt_arr[k][HART_LSB +: HART_W] == HART_W'(h));
    end

    irq_first_pick #(
      .N     (NUM_SRC),
      .IDX_W (SRC_W)
    ) u_pick (
      .cand_i  (pend_vec & route[h]),
      .found_o (pick_found[h]),
      .num_o   (pick_num[h])
    );

    assign irq_o[h] = gie_q && |(en_vec & pend_vec & route[h]);
  end

  // read path
  logic [31:0] rd_val, rdata_q;

  always_comb begin
    rd_val = '0;
    if (hit_dom) begin
      rd_val[GIE_BIT] = gie_q;
    end else if (hit_cfg) begin
      for (int k = 0; k < NUM_SRC; k++)
        if (cfg_idx == WIDX_W'(k + 1)) rd_val = 32'(cfg_arr[k]);
    end else if (hit_tgt) begin
      for (int k = 0; k < NUM_SRC; k++)
        if (tgt_idx == WIDX_W'(k + 1)) rd_val = tgt_arr[k];
    end else if (hit_claim && pick_found[claim_hart]) begin
      rd_val = claim_word(10'(pick_num[claim_hart]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_domain_ctrl_chk.sv
module irq_domain_ctrl_chk
  import irq_domain_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned NUM_HART = 2,
  parameter int unsigned ADDR_W   = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [NUM_HART-1:0] irq_o,
  input logic                gie_i,
  input logic [NUM_SRC-1:0]  pend_i,
  input logic [NUM_SRC-1:0]  en_i,
  input logic [NUM_SRC-1:0]  dlg_i,
  input logic [NUM_SRC-1:0]  det_i,
  input logic [NUM_SRC-1:0]  claim_clr_i
);

  AST_DOM_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFS_DOMAIN) && !wdata_i[GIE_BIT]) |=> (irq_o == '0)); // R1

  AST_NO_PEND_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |=> ((pend_i & ~$past(pend_i)) == '0)); // R2

  AST_CLAIM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_clr_i)); // R9

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_k
    AST_DLG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dlg_i[k] && !claim_clr_i[k]) |=> $stable(pend_i[k])); // R3

    AST_DET_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (det_i[k] && !claim_clr_i[k]) |=> $stable(pend_i[k])); // R4

    AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(OFS_EN_SET) && wdata_i == 32'(k + 1)) |=> en_i[k]); // R7
  end

endmodule

bind irq_domain_ctrl irq_domain_ctrl_chk #(
  .NUM_SRC  (NUM_SRC),
  .NUM_HART (NUM_HART),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .irq_o       (irq_o),
  .gie_i       (gie_q),
  .pend_i      (pend_vec),
  .en_i        (en_vec),
  .dlg_i       (dlg_vec),
  .det_i       (det_vec),
  .claim_clr_i (claim_clr)
);

// File: tb/irq_domain_ctrl_tb_top.sv
module irq_domain_ctrl_tb_top;

  localparam int unsigned NS = 8;
  localparam int unsigned NH = 2;
  localparam int unsigned AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NS-1:0] src = '0;
  logic [NH-1:0] irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irq_domain_ctrl #(.NUM_SRC(NS), .NUM_HART(NH), .ADDR_W(AW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .src_i (src), .irq_o (irq)
  );

  function automatic logic [AW-1:0] a_cfg(int n);   return AW'(4 * n); endfunction
  function automatic logic [AW-1:0] a_tgt(int n);   return AW'(32'h3000 + 4 * n); endfunction
  function automatic logic [AW-1:0] a_win(int h, int o); return AW'(32'h4000 + 32 * h + o); endfunction
  function automatic logic [31:0] cw(int n); return 32'(n) << 16; endfunction

  localparam logic [AW-1:0] A_DOM = '0;
  localparam logic [AW-1:0] A_SET = AW'(32'h1EDC);
  localparam logic [AW-1:0] A_CLR = AW'(32'h1FDC);

  function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire_q = 1'b0;

  always @(posedge clk) rd_fire_q <= rst_n && req && !we;

  always @(negedge clk) begin
    if (rd_fire_q) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty", rdata, '0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic line(int k, logic v);
    @(negedge clk); src[k] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_irq(logic [NH-1:0] e, string t);
    check(irq === e, t, 32'(irq), 32'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(2'b00, "R11 reset irq");
    rd(A_DOM, 32'h0, "R1 reset domain");

    wr(A_DOM, 32'hFFFF_FFFF);
    rd(A_DOM, 32'h100, "R1 only enable kept");

    wr(a_cfg(1), 32'hFFFF_FFFF);
    rd(a_cfg(1), 32'h7FF, "R13 cfg keeps 10:0");
    wr(a_cfg(1), 32'h4);
    rd(a_cfg(1), 32'h4, "R13 cfg readback");
    wr(a_tgt(2), 32'h0004_0000);
    rd(a_tgt(2), 32'h0004_0000, "R8 target readback");

    // rising edge on source 1, hart 0
    wr(A_SET, 32'd1);
    line(0, 1'b1);
    chk_irq(2'b01, "R5 rise sets pending");
    rd(a_win(0, 32'h1C), cw(1), "R9 claim source 1");
    chk_irq(2'b00, "R9 claim clears pending");
    rd(a_win(0, 32'h1C), 32'h0, "R9 empty claim");
    line(0, 1'b0);
    line(0, 1'b1);
    chk_irq(2'b01, "R5 second rise");
    line(0, 1'b0);
    chk_irq(2'b00, "R5 fall clears in rise mode");

    // falling edge on source 2, hart 1
    wr(a_cfg(2), 32'h5);
    wr(A_SET, 32'd2);
    line(1, 1'b1);
    chk_irq(2'b00, "R5 rise ignored in fall mode");
    line(1, 1'b0);
    chk_irq(2'b10, "R5 fall sets in fall mode");
    rd(a_win(1, 32'h1C), cw(2), "R9 claim source 2 on hart 1");

    // level high source 3; claim collides with set
    wr(a_cfg(3), 32'h6);
    wr(A_SET, 32'd3);
    line(2, 1'b1);
    chk_irq(2'b01, "R6 level high active");
    rd(a_win(0, 32'h1C), cw(3), "R12 claim level source");
    chk_irq(2'b01, "R12 set wins over claim");
    rd(a_win(0, 32'h1C), cw(3), "R12 second claim same source");
    line(2, 1'b0);
    chk_irq(2'b00, "R6 level high released");

    // level low source 4
    wr(A_SET, 32'd4);
    wr(a_cfg(4), 32'h7);
    repeat (2) @(negedge clk);
    chk_irq(2'b01, "R6 level low active");
    line(3, 1'b1);
    chk_irq(2'b00, "R6 level low released");

    // delegate on source 5
    wr(a_cfg(5), 32'h404);
    wr(A_SET, 32'd5);
    line(4, 1'b1);
    line(4, 1'b0);
    chk_irq(2'b00, "R3 delegated source quiet");
    rd(a_win(0, 32'h1C), 32'h0, "R3 delegated not pending");

    // detached and reserved
    wr(a_cfg(6), 32'h1);
    wr(a_cfg(7), 32'h2);
    wr(A_SET, 32'd6);
    wr(A_SET, 32'd7);
    line(5, 1'b1); line(6, 1'b1);
    line(5, 1'b0); line(6, 1'b0);
    chk_irq(2'b00, "R4 detached/reserved quiet");
    rd(a_win(0, 32'h1C), 32'h0, "R4 detached/reserved not pending");

    // enable by number
    wr(A_CLR, 32'd1);
    line(0, 1'b1);
    chk_irq(2'b00, "R7 disabled source no irq");
    wr(A_SET, 32'd17);
    wr(A_SET, 32'd0);
    chk_irq(2'b00, "R7 out-of-range numbers ignored");
    rd(A_SET, 32'h0, "R7 set location reads 0");
    rd(A_CLR, 32'h0, "R7 clear location reads 0");
    wr(A_SET, 32'd1);
    chk_irq(2'b01, "R7 enable by number");
    wr(A_CLR, 32'd1);
    chk_irq(2'b00, "R11 disable drops irq");
    rd(a_win(0, 32'h1C), cw(1), "R9 claim ignores enable");
    line(0, 1'b0);

    // ordering on hart 1
    wr(a_cfg(7), 32'h4); wr(a_cfg(8), 32'h4);
    wr(a_tgt(7), 32'h0004_0000); wr(a_tgt(8), 32'h0004_0000);
    wr(A_SET, 32'd7); wr(A_SET, 32'd8);
    @(negedge clk); src[7] = 1'b1; src[6] = 1'b1;
    repeat (3) @(negedge clk);
    chk_irq(2'b10, "R11 hart 1 only");
    rd(a_win(1, 32'h1C), cw(7), "R9 lowest number first");
    rd(a_win(1, 32'h1C), cw(8), "R9 next number");
    rd(a_win(1, 32'h1C), 32'h0, "R9 none left");

    // claim write and inert window registers
    line(6, 1'b0);
    line(6, 1'b1);
    wr(a_win(1, 32'h1C), 32'hFFFF_FFFF);
    chk_irq(2'b10, "R10 claim write no effect");
    rd(a_win(1, 32'h00), 32'h0, "R10 delivery reads 0");
    rd(a_win(1, 32'h18), 32'h0, "R10 top reads 0");
    rd(a_win(1, 32'h1C), cw(7), "R10 pending kept after write");

    // global enable
    line(7, 1'b0);
    line(7, 1'b1);
    chk_irq(2'b10, "R11 source 8 pending");
    wr(A_DOM, 32'h0);
    chk_irq(2'b00, "R1 enable off silences irq");
    rd(a_win(1, 32'h1C), cw(8), "R1 claim still works when off");
    line(7, 1'b0);
    line(7, 1'b1);
    wr(A_DOM, 32'h100);
    chk_irq(2'b00, "R2 no pending set while off");
    rd(a_win(1, 32'h1C), 32'h0, "R2 nothing to claim");

    // unmapped
    wr(AW'(32'h2000), 32'hFFFF_FFFF);
    rd(AW'(32'h2000), 32'h0, "R13 unmapped reads 0");
    rd(AW'(32'h0006), 32'h0, "R13 misaligned reads 0");
    rd(a_cfg(NS + 1), 32'h0, "R13 beyond last source reads 0");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(1'b0, "R14 reads outstanding", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule